// File: doc/BRIEF.md
# Register-Register Integer ALU

This block is the combinational execute step for register-register integer instructions on a core whose register width is set by `XLEN`, either 32 or 64. It takes the 32-bit instruction word and the two operand values that the register file has already supplied. From these it produces the field indices, the result, a write strobe for the destination register and an illegal-instruction flag.

Ten operations are supported: add, subtract, signed and unsigned set-less-than, the three bitwise logic operations, and left, logical-right and arithmetic-right shifts. Every functional unit evaluates on every instruction. The result is picked by an AND-OR network driven by one-hot strobes. No operation takes a shorter or longer path depending on operand values, so timing does not depend on the data.

The surrounding pipeline registers the outputs. It uses `wrEn` together with `rdIdx` to update the register file, and routes `illegalInstr` to its own trap logic.

Top module: `rrIntAlu`

## Requirements
- R1: `rs2Idx` equals instruction bits 24..20, `rs1Idx` equals bits 19..15 and `rdIdx` equals bits 11..7, for every instruction word.
- R2: Operation decode requires opcode bits 6..0 = 0110011. funct3 (bits 14..12) selects 000 add/sub, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 shift right, 110 or, 111 and. funct7 (bits 31..25) = 0000000 selects the base operation and 0100000 selects subtract (funct3 000) or arithmetic shift right (funct3 101). Add and subtract wrap modulo 2^XLEN.
- R3: Signed less-than treats both operands as two's complement. It returns 1 in bit 0 when srcA < srcB and 0 otherwise, and all upper result bits are 0.
- R4: Unsigned less-than makes the same comparison with both operands unsigned, with the same bit-0 result format.
- R5: AND, OR and XOR act bit by bit across all XLEN bits.
- R6: The shift distance is srcB[4:0] when XLEN is 32 and srcB[5:0] when XLEN is 64. Higher srcB bits have no effect.
- R7: Shift left fills the low bits with zeros, and logical shift right fills the vacated high bits with zeros. Arithmetic shift right fills them with copies of srcA's top bit.
- R8: Any other opcode, and any funct7/funct3 pair not listed in R2, raises `illegalInstr`, clears `wrEn` and drives `result` to 0.
- R9: For a legal instruction, `wrEn` is 1 exactly when `rdIdx` is not 0.
- R10: The same RTL works with XLEN of 32 and of 64, and the result occupies the full XLEN width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word being executed |
| srcA | input | XLEN | First operand value |
| srcB | input | XLEN | Second operand value |
| result | output | XLEN | Operation result |
| rs1Idx | output | 5 | First source register index |
| rs2Idx | output | 5 | Second source register index |
| rdIdx | output | 5 | Destination register index |
| wrEn | output | 1 | Destination write strobe |
| illegalInstr | output | 1 | Instruction word not recognised |

## Verification
Hand-computed vectors isolate the edges. The most-negative against the most-positive value separates signed from unsigned ordering. Equal operands show that less-than is strict. An all-ones operand against 1 gives opposite answers for the signed and unsigned compares. Shift distances with bits set above the used field show that those bits are masked, and a negative operand shifted right tells zero fill from sign fill. Beyond those vectors, every operation is swept over a set of operand pairs on both a 32-bit and a 64-bit instance and compared with a behavioural model. Directed words with a zero destination, a foreign opcode and unlisted funct7 values cover the write-strobe and illegal paths.

// File: rtl/rrAluPkg.sv
package rrAluPkg;

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] F7_BASE  = 7'b0000000;
  localparam logic [6:0] F7_ALT   = 7'b0100000;

  // One-hot result selects plus adder and shifter modes.
  typedef struct packed {
    logic subMode;   // adder computes a - b
    logic selSum;
    logic selSlt;
    logic selSltu;
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selShl;
    logic selShr;
    logic arith;     // right shift fills with the sign bit
  } aluStrobes_t;

endpackage

// File: rtl/rrAluDecode.sv
module rrAluDecode
  import rrAluPkg::*;
(
  input  logic [6:0]  opcode,
  input  logic [2:0]  funct3,
  input  logic [6:0]  funct7,
  output aluStrobes_t strobes,
  output logic        legal
);

  always_comb begin
    strobes = '0;
    legal   = 1'b0;
    if (opcode == OPC_REG) begin
      if (funct7 == F7_BASE) begin
        legal = 1'b1;
        unique case (funct3)
          3'b000: strobes.selSum = 1'b1;
          3'b001: strobes.selShl = 1'b1;
          3'b010: begin strobes.subMode = 1'b1; strobes.selSlt  = 1'b1; end
          3'b011: begin strobes.subMode = 1'b1; strobes.selSltu = 1'b1; end
          3'b100: strobes.selXor = 1'b1;
          3'b101: strobes.selShr = 1'b1;
          3'b110: strobes.selOr  = 1'b1;
          3'b111: strobes.selAnd = 1'b1;
          default: legal = 1'b0;
        endcase
      end else if (funct7 == F7_ALT) begin
        case (funct3)
          3'b000: begin
            legal = 1'b1;
            strobes.subMode = 1'b1;
            strobes.selSum  = 1'b1;
          end
          3'b101: begin
            legal = 1'b1;
            strobes.selShr = 1'b1;
            strobes.arith  = 1'b1;
          end
          default: legal = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/rrAddSub.sv
module rrAddSub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic            subMode,
  output logic [XLEN-1:0] sum,
  output logic            ltSigned,
  output logic            ltUnsigned
);

  localparam int MSB = XLEN - 1;

  logic [XLEN:0]   wide;
  logic [XLEN-1:0] opBx;

  assign opBx = opB ^ {XLEN{subMode}};
  assign wide = {1'b0, opA} + {1'b0, opBx} + {{XLEN{1'b0}}, subMode};
  assign sum  = wide[XLEN-1:0];

  // With subMode set, a missing carry out means a borrow: a < b unsigned.
  assign ltUnsigned = ~wide[XLEN];
  // Differing signs decide directly; equal signs cannot overflow.
  assign ltSigned   = (opA[MSB] ^ opB[MSB]) ? opA[MSB] : sum[MSB];

endmodule

// File: rtl/rrShifter.sv
module rrShifter #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] value,
  input  logic [SHW-1:0]  amount,
  input  logic            leftDir,
  input  logic            arith,
  output logic [XLEN-1:0] shifted
);

  logic [XLEN-1:0] revIn;
  logic [XLEN-1:0] revOut;
  logic [XLEN-1:0] stage [0:SHW];
  logic            fillBit;

  // Left shifts reuse the right-shift ladder on a bit-reversed operand.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign revIn[i]  = value[XLEN-1-i];
    assign revOut[i] = stage[SHW][XLEN-1-i];
  end

  assign fillBit  = arith & value[XLEN-1];
  assign stage[0] = leftDir ? revIn : value;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amount[k]
      ? {{STEP{fillBit}}, stage[k][XLEN-1:STEP]}
      : stage[k];
  end

  assign shifted = leftDir ? revOut : stage[SHW];

endmodule

// File: rtl/rrAluDatapath.sv
module rrAluDatapath
  import rrAluPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  aluStrobes_t     strobes,
  output logic [XLEN-1:0] result
);

  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] sumVal;
  logic [XLEN-1:0] shiftVal;
  logic            ltS;
  logic            ltU;
  logic [XLEN-1:0] cmpVal;

  rrAddSub #(.XLEN(XLEN)) u_addSub (
    .opA       (srcA),
    .opB       (srcB),
    .subMode   (strobes.subMode),
    .sum       (sumVal),
    .ltSigned  (ltS),
    .ltUnsigned(ltU)
  );

  rrShifter #(.XLEN(XLEN), .SHW(SHW)) u_shifter (
    .value  (srcA),
    .amount (srcB[SHW-1:0]),
    .leftDir(strobes.selShl),
    .arith  (strobes.arith),
    .shifted(shiftVal)
  );

  assign cmpVal = {{(XLEN-1){1'b0}},
                   (strobes.selSlt & ltS) | (strobes.selSltu & ltU)};

  // Fixed AND-OR select: every unit is always evaluated.
  assign result = ({XLEN{strobes.selSum}}                   & sumVal)
                | ({XLEN{strobes.selShl | strobes.selShr}}  & shiftVal)
                | ({XLEN{strobes.selAnd}}                   & (srcA & srcB))
                | ({XLEN{strobes.selOr}}                    & (srcA | srcB))
                | ({XLEN{strobes.selXor}}                   & (srcA ^ srcB))
                | cmpVal;

endmodule

// File: rtl/rrIntAlu.sv
module rrIntAlu
  import rrAluPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instrWord,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result,
  output logic [4:0]      rs1Idx,
  output logic [4:0]      rs2Idx,
  output logic [4:0]      rdIdx,
  output logic            wrEn,
  output logic            illegalInstr
);

  aluStrobes_t strobes;
  logic        legal;

  assign rs2Idx = instrWord[24:20];
  assign rs1Idx = instrWord[19:15];
  assign rdIdx  = instrWord[11:7];

  rrAluDecode u_decode (
    .opcode (instrWord[6:0]),
    .funct3 (instrWord[14:12]),
    .funct7 (instrWord[31:25]),
    .strobes(strobes),
    .legal  (legal)
  );

  rrAluDatapath #(.XLEN(XLEN)) u_datapath (
    .srcA   (srcA),
    .srcB   (srcB),
    .strobes(strobes),
    .result (result)
  );

  assign wrEn         = legal & (rdIdx != 5'd0);
  assign illegalInstr = ~legal;

endmodule

// File: rtl/rrIntAluChecker.sv
module rrIntAluChecker #(
  parameter int XLEN = 64
) (
  input logic [31:0]     instrWord,
  input logic [XLEN-1:0] srcA,
  input logic [XLEN-1:0] srcB,
  input logic [XLEN-1:0] result,
  input logic [4:0]      rdIdx,
  input logic            wrEn,
  input logic            illegalInstr
);

  localparam int SHW = $clog2(XLEN);

  logic isReg;
  logic isBase;
  logic isAlt;
  assign isReg  = instrWord[6:0] == 7'b0110011;
  assign isBase = isReg && instrWord[31:25] == 7'b0000000;
  assign isAlt  = isReg && instrWord[31:25] == 7'b0100000;

  always_comb begin
    // R8: illegal word never writes and yields zero
    p_illegal_quiet_r8: assert (!illegalInstr || (!wrEn && result == '0))
      else $error("p_illegal_quiet_r8");
    // R9: register zero is never written
    p_x0_no_write_r9: assert (rdIdx != 5'd0 || !wrEn)
      else $error("p_x0_no_write_r9");
    // R1: write goes to the destination field
    p_rd_field_r1: assert (!wrEn || rdIdx == instrWord[11:7])
      else $error("p_rd_field_r1");
    // R3, R4: compare results use bit 0 only
    p_cmp_upper_zero_r3: assert (!(isBase && instrWord[13:12] == 2'b10 && instrWord[14] == 1'b0
                                   || isBase && instrWord[14:12] == 3'b011)
                                 || result[XLEN-1:1] == '0)
      else $error("p_cmp_upper_zero_r3");
    // R7: arithmetic right shift keeps a negative operand negative
    p_sra_sign_r7: assert (!(isAlt && instrWord[14:12] == 3'b101 && srcA[XLEN-1])
                           || result[XLEN-1])
      else $error("p_sra_sign_r7");
    // R7: logical right shift by a nonzero distance clears the top bit
    p_srl_fill_r7: assert (!(isBase && instrWord[14:12] == 3'b101 && srcB[SHW-1:0] != '0)
                           || !result[XLEN-1])
      else $error("p_srl_fill_r7");
    // R5: AND never sets a bit absent from either operand
    p_and_subset_r5: assert (!(isBase && instrWord[14:12] == 3'b111)
                             || (result & ~(srcA & srcB)) == '0)
      else $error("p_and_subset_r5");
  end

endmodule

bind rrIntAlu rrIntAluChecker #(.XLEN(XLEN)) u_chk (
  .instrWord   (instrWord),
  .srcA        (srcA),
  .srcB        (srcB),
  .result      (result),
  .rdIdx       (rdIdx),
  .wrEn        (wrEn),
  .illegalInstr(illegalInstr)
);

// File: tb/rrIntAlu_tb.sv
module rrIntAlu_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [4:0] r2,
                                        input logic [4:0] r1, input logic [2:0] f3,
                                        input logic [4:0] rd);
    return {f7, r2, r1, f3, rd, 7'b0110011};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES  = '1;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{rtype(7'h00,5'd2,5'd1,3'b000,5'd5), 64'd5,  64'd7,  64'd12},
    '{rtype(7'h00,5'd2,5'd1,3'b000,5'd5), MAX64,  64'd1,  MIN64},
    '{rtype(7'h20,5'd2,5'd1,3'b000,5'd5), 64'd0,  64'd1,  ONES},
    '{rtype(7'h00,5'd2,5'd1,3'b010,5'd5), ONES,   64'd1,  64'd1},
    '{rtype(7'h00,5'd2,5'd1,3'b011,5'd5), ONES,   64'd1,  64'd0},
    '{rtype(7'h00,5'd2,5'd1,3'b010,5'd5), MIN64,  MAX64,  64'd1},
    '{rtype(7'h00,5'd2,5'd1,3'b010,5'd5), MAX64,  MAX64,  64'd0},
    '{rtype(7'h00,5'd2,5'd1,3'b011,5'd5), 64'd1,  64'd2,  64'd1},
    '{rtype(7'h00,5'd2,5'd1,3'b111,5'd5), 64'hF0F0, 64'hFF00, 64'hF000},
    '{rtype(7'h00,5'd2,5'd1,3'b110,5'd5), 64'hF0, 64'h0F, 64'hFF},
    '{rtype(7'h00,5'd2,5'd1,3'b100,5'd5), 64'hFF, 64'h0F, 64'hF0},
    '{rtype(7'h00,5'd2,5'd1,3'b001,5'd5), 64'd1,  64'h41, 64'd2},
    '{rtype(7'h00,5'd2,5'd1,3'b101,5'd5), MIN64,  64'd63, 64'd1},
    '{rtype(7'h20,5'd2,5'd1,3'b101,5'd5), MIN64,  64'd63, ONES},
    '{rtype(7'h20,5'd2,5'd1,3'b101,5'd5), MIN64,  64'h104, 64'hF800_0000_0000_0000}
  };
  localparam string VREQ [NV] = '{"R2","R2","R2","R3","R4","R3","R3","R4",
                                  "R5","R5","R5","R6","R7","R7","R6"};

  // operation list: funct7, funct3
  localparam logic [6:0] OPF7 [10] = '{7'h00,7'h20,7'h00,7'h00,7'h00,7'h00,7'h00,7'h00,7'h00,7'h20};
  localparam logic [2:0] OPF3 [10] = '{3'd0, 3'd0, 3'd2, 3'd3, 3'd7, 3'd6, 3'd4, 3'd1, 3'd5, 3'd5};

  localparam int NP = 8;
  localparam logic [63:0] PA64 [NP] = '{64'd0, 64'd1, MAX64, MIN64, MIN64, ONES,
                                        64'h1234_5678_9ABC_DEF0, 64'd5};
  localparam logic [63:0] PB64 [NP] = '{64'd0, 64'd2, MIN64, MAX64, MIN64, 64'd1,
                                        64'hFFFF_FFFF_FFFF_FFC5, 64'h7F};
  localparam logic [31:0] PA32 [NP] = '{32'd0, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000,
                                        32'h8000_0000, 32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'd5};
  localparam logic [31:0] PB32 [NP] = '{32'd0, 32'd2, 32'h8000_0000, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'd1, 32'hFFFF_FFE7, 32'h3F};

  function automatic logic [63:0] mdl64(input logic [2:0] f3, input logic alt,
                                        input logic [63:0] a, input logic [63:0] b);
    case (f3)
      3'd0: return alt ? a - b : a + b;
      3'd1: return a << b[5:0];
      3'd2: return {63'd0, $signed(a) < $signed(b)};
      3'd3: return {63'd0, a < b};
      3'd4: return a ^ b;
      3'd5: return alt ? 64'($signed(a) >>> b[5:0]) : a >> b[5:0];
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic [31:0] mdl32(input logic [2:0] f3, input logic alt,
                                        input logic [31:0] a, input logic [31:0] b);
    case (f3)
      3'd0: return alt ? a - b : a + b;
      3'd1: return a << b[4:0];
      3'd2: return {31'd0, $signed(a) < $signed(b)};
      3'd3: return {31'd0, a < b};
      3'd4: return a ^ b;
      3'd5: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  logic [31:0] ins64, ins32;
  logic [63:0] a64, b64, res64;
  logic [31:0] a32, b32, res32;
  logic [4:0]  rs1_64, rs2_64, rd_64, rs1_32, rs2_32, rd_32;
  logic        we64, ill64, we32, ill32;

  rrIntAlu #(.XLEN(64)) u_dut (
    .instrWord(ins64), .srcA(a64), .srcB(b64), .result(res64),
    .rs1Idx(rs1_64), .rs2Idx(rs2_64), .rdIdx(rd_64),
    .wrEn(we64), .illegalInstr(ill64)
  );

  rrIntAlu #(.XLEN(32)) u_dut32 (
    .instrWord(ins32), .srcA(a32), .srcB(b32), .result(res32),
    .rs1Idx(rs1_32), .rs2Idx(rs2_32), .rdIdx(rd_32),
    .wrEn(we32), .illegalInstr(ill32)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i64, input logic [63:0] x, input logic [63:0] y,
                       input logic [31:0] i32, input logic [31:0] x32, input logic [31:0] y32);
    @(posedge clk);
    ins64 = i64; a64 = x; b64 = y;
    ins32 = i32; a32 = x32; b32 = y32;
    @(negedge clk);
  endtask

  initial begin
    ins64 = '0; a64 = '0; b64 = '0;
    ins32 = '0; a32 = '0; b32 = '0;
    @(negedge clk);
    // Initial all-zero word: opcode 0 is not a register op (R8)
    chk("R8 idle illegal", {63'd0, ill64}, 64'd1);
    chk("R8 idle no write", {63'd0, we64}, 64'd0);
    chk("R8 idle result", res64, 64'd0);

    // Vector table, 64-bit instance
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].ins, VECS[v].a, VECS[v].b, 32'd0, 32'd0, 32'd0);
      chk(VREQ[v], res64, VECS[v].exp);
      chk("R9 write on rd=5", {63'd0, we64}, 64'd1);
    end

    // Model sweep over all operations and both widths (R2..R7, R10)
    for (int o = 0; o < 10; o++) begin
      for (int p = 0; p < NP; p++) begin
        drive(rtype(OPF7[o], 5'd3, 5'd4, OPF3[o], 5'd9), PA64[p], PB64[p],
              rtype(OPF7[o], 5'd3, 5'd4, OPF3[o], 5'd9), PA32[p], PB32[p]);
        chk("R10 sweep 64", res64, mdl64(OPF3[o], OPF7[o][5], PA64[p], PB64[p]));
        chk("R10 sweep 32", {32'd0, res32}, {32'd0, mdl32(OPF3[o], OPF7[o][5], PA32[p], PB32[p])});
      end
    end

    // R6/R7 on 32 bits: distance 0x21 masks to 1; sign fill by 31
    drive(64'd0, 64'd0, 64'd0, rtype(7'h00,5'd2,5'd1,3'b001,5'd7), 32'd1, 32'h21);
    chk("R6 sll32 masked", {32'd0, res32}, 64'd2);
    drive(64'd0, 64'd0, 64'd0, rtype(7'h20,5'd2,5'd1,3'b101,5'd7), 32'h8000_0000, 32'd31);
    chk("R7 sra32 fill", {32'd0, res32}, 64'hFFFF_FFFF);
    drive(64'd0, 64'd0, 64'd0, rtype(7'h00,5'd2,5'd1,3'b010,5'd7), 32'h8000_0000, 32'h7FFF_FFFF);
    chk("R3 slt32 min<max", {32'd0, res32}, 64'd1);

    // R1: field extraction
    drive(rtype(7'h00, 5'd17, 5'd22, 3'b000, 5'd30), 64'd0, 64'd0, 32'd0, 32'd0, 32'd0);
    chk("R1 rs2", {59'd0, rs2_64}, 64'd17);
    chk("R1 rs1", {59'd0, rs1_64}, 64'd22);
    chk("R1 rd",  {59'd0, rd_64},  64'd30);

    // R9: destination zero suppresses the write, flag stays low
    drive(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd0), 64'd3, 64'd4, 32'd0, 32'd0, 32'd0);
    chk("R9 rd0 no write", {63'd0, we64}, 64'd0);
    chk("R9 rd0 legal", {63'd0, ill64}, 64'd0);

    // R8: foreign opcode, alt funct7 with funct3 001, unknown funct7
    drive(32'h0020_82B3 ^ 32'h0000_0020, 64'd3, 64'd4, 32'd0, 32'd0, 32'd0);
    chk("R8 opcode illegal", {63'd0, ill64}, 64'd1);
    chk("R8 opcode result", res64, 64'd0);
    drive(rtype(7'h20, 5'd2, 5'd1, 3'b001, 5'd5), 64'd3, 64'd4, 32'd0, 32'd0, 32'd0);
    chk("R8 alt f3 illegal", {63'd0, ill64}, 64'd1);
    chk("R8 alt f3 no write", {63'd0, we64}, 64'd0);
    drive(rtype(7'h01, 5'd2, 5'd1, 3'b000, 5'd5), 64'd3, 64'd4, 32'd0, 32'd0, 32'd0);
    chk("R8 f7 illegal", {63'd0, ill64}, 64'd1);
    chk("R8 f7 result", res64, 64'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule